// File: doc/BRIEF.md
# Dual-Source 16-bit Up-Counter with Overflow Interrupt

This block is a 16-bit up-counter that takes its count events from one of two sources. In timer mode it advances on a one-cycle tick-enable supplied by a prescaler outside the block. In event mode it advances on chosen transitions of an asynchronous external input. The external input is synchronized and edge-detected inside the block. Software controls the counter through a byte-wide register bus. Through that bus it starts and stops the counter, chooses the source and the edge, clears the count, loads the count while the counter is halted, and reads the count.

When the counter rolls over from all ones to zero, it raises a sticky overflow flag. An interrupt request is driven while the flag is set and the interrupt enable is on. A clear of the count that lands in the same cycle as a rollover cancels that rollover's flag. A 16-bit read is two byte reads, low byte first. The low-byte read captures the high byte, so the two bytes always belong to one count value even while the counter runs.

Top module: `evtmr_top`

## Requirements
- R1: After reset the count is 16'h0000, the interrupt request is low, and the control byte (address 0) reads 8'h20: halted, interrupt disabled, flag clear, timer source, and bit 5 reading 1.
- R2: With control bits 4:3 = 2'b00 and the counter running, the count goes up by one in each cycle where tick_en is high, and the external input has no effect.
- R3: With control bits 4:3 = 2'b01 the counter counts rising edges of ext_in. With 2'b10 it counts falling edges, and with 2'b11 it counts both. In these three modes tick_en has no effect.
- R4: Control bit 0 is the run bit. While it is 0 the count holds, whatever tick_en and ext_in do.
- R5: A rollover from 16'hFFFF to 16'h0000 sets the overflow flag (control bit 2). The irq output is high exactly when that flag is 1 and the interrupt enable (control bit 1) is 1.
- R6: A control write with bit 2 = 0 clears the overflow flag. A control write with bit 2 = 1 leaves the flag as it is.
- R7: A control write with bit 5 = 0 sets the count to 16'h0000. If that write falls in the cycle of a rollover, the flag stays clear. Bit 5 always reads back as 1.
- R8: A write to address 1 loads the low count byte and a write to address 2 loads the high count byte, but only while the counter is halted. While it runs, such writes are ignored.
- R9: A read of address 1 returns the low count byte and captures the high byte. A later read of address 2 returns that captured byte, not the live one.
- R10: External pulses whose high and low phases are each two clock cycles long are all counted, in every edge mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle tick enable for timer mode |
| ext_in | input | 1 | Asynchronous external event input |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on the next cycle |
| bus_addr | input | 2 | Register select: 0 control, 1 count low, 2 count high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Overflow interrupt request |

## Verification
A software clear of the count and a rollover of the count can fall in the same clock cycle. The bench provokes this by loading 16'hFFFF, starting the counter, and then raising tick_en at the same falling edge where it presents a control write with bit 5 at 0. That write keeps the run bit set. The outcome is judged by reading back a zero count, a clear overflow flag with bit 5 at 1, and a low irq. A bound property also requires that a clear taken while the flag is low leaves the flag low.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  typedef enum logic [1:0] {
    SRC_TICK = 2'b00,
    SRC_RISE = 2'b01,
    SRC_FALL = 2'b10,
    SRC_BOTH = 2'b11
  } src_e;

  // control byte layout
  localparam int unsigned CTL_RUN  = 0;
  localparam int unsigned CTL_IE   = 1;
  localparam int unsigned CTL_OVF  = 2;
  localparam int unsigned CTL_SRC  = 3;
  localparam int unsigned CTL_KEEP = 5;
  localparam int unsigned CTL_W    = 6;

  // register addresses
  localparam int unsigned ADR_CTL = 0;
  localparam int unsigned ADR_LO  = 1;
  localparam int unsigned ADR_HI  = 2;
endpackage

// File: rtl/evtmr_sync_edge.sv
module evtmr_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[LAST];
  end

  assign rise = chain_q[LAST] & ~prev_q;
  assign fall = ~chain_q[LAST] & prev_q;
endmodule

// File: rtl/evtmr_count.sv
module evtmr_count
  import evtmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  src_e                  src,
  input  logic                  tick_en,
  input  logic                  rise,
  input  logic                  fall,
  input  logic                  clr,
  input  logic                  ld_lo,
  input  logic                  ld_hi,
  input  logic [DATA_W-1:0]     ld_data,
  output logic [2*DATA_W-1:0]   cnt,
  output logic                  step,
  output logic                  wrap
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  always_comb begin
    case (src)
      SRC_TICK: hit = tick_en;
      SRC_RISE: hit = rise;
      SRC_FALL: hit = fall;
      default:  hit = rise | fall;
    endcase
  end

  assign step = run & hit;
  // clear takes priority: a rollover cancelled by a clear raises no flag
  assign wrap = step & (&cnt_q) & ~clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (!run && (ld_lo || ld_hi)) begin
      if (ld_lo) cnt_q[DATA_W-1:0]     <= ld_data;
      if (ld_hi) cnt_q[CNT_W-1:DATA_W] <= ld_data;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/evtmr_regs.sv
module evtmr_regs
  import evtmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CTL_W-1:0]     ctl_wdata,
  input  logic [2*DATA_W-1:0]  cnt,
  input  logic                 wrap,
  output logic                 run_q,
  output logic                 ie_q,
  output src_e                 src_q,
  output logic                 flag_q,
  output logic                 clr_stb,
  output logic                 ld_lo,
  output logic                 ld_hi,
  output logic [DATA_W-1:0]    rdata,
  output logic                 irq
);
  localparam int unsigned CNT_W = 2 * DATA_W;
  localparam int unsigned PAD_W = DATA_W - CTL_W;

  logic              sel_ctl, sel_lo, sel_hi, ctl_wr;
  logic              flag_n, ie_n;
  logic [DATA_W-1:0] snap_q, rdata_q;
  logic              irq_q;

  assign sel_ctl = (addr == ADDR_W'(ADR_CTL));
  assign sel_lo  = (addr == ADDR_W'(ADR_LO));
  assign sel_hi  = (addr == ADDR_W'(ADR_HI));
  assign ctl_wr  = wr & sel_ctl;
  assign clr_stb = ctl_wr & ~ctl_wdata[CTL_KEEP];
  assign ld_lo   = wr & sel_lo;
  assign ld_hi   = wr & sel_hi;

  always_comb begin
    // a hardware set wins over a software clear in the same cycle
    if (wrap)                           flag_n = 1'b1;
    else if (ctl_wr && !ctl_wdata[CTL_OVF]) flag_n = 1'b0;
    else                                flag_n = flag_q;
    ie_n = ctl_wr ? ctl_wdata[CTL_IE] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      src_q  <= SRC_TICK;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      ie_q   <= ie_n;
      irq_q  <= flag_n & ie_n;
      if (ctl_wr) begin
        run_q <= ctl_wdata[CTL_RUN];
        src_q <= src_e'(ctl_wdata[CTL_SRC+1:CTL_SRC]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      rdata_q <= '0;
    end else if (rd) begin
      if (sel_ctl) begin
        rdata_q <= {{PAD_W{1'b0}}, 1'b1, src_q, flag_q, ie_q, run_q};
      end else if (sel_lo) begin
        rdata_q <= cnt[DATA_W-1:0];
        snap_q  <= cnt[CNT_W-1:DATA_W];
      end else if (sel_hi) begin
        rdata_q <= snap_q;
      end else begin
        rdata_q <= '0;
      end
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;
endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
  import evtmr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              ext_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic             rise, fall;
  logic             run_q, ie_q, flag_q;
  src_e             src_q;
  logic             clr_stb, ld_lo, ld_hi;
  logic             step, wrap;
  logic [CNT_W-1:0] cnt_q;

  evtmr_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .async_in(ext_in), .rise(rise), .fall(fall)
  );

  evtmr_count #(.DATA_W(DATA_W)) u_count (
    .clk(clk), .rst(rst), .run(run_q), .src(src_q), .tick_en(tick_en),
    .rise(rise), .fall(fall), .clr(clr_stb), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .ld_data(bus_wdata), .cnt(cnt_q), .step(step), .wrap(wrap)
  );

  evtmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .ctl_wdata(bus_wdata[CTL_W-1:0]), .cnt(cnt_q), .wrap(wrap),
    .run_q(run_q), .ie_q(ie_q), .src_q(src_q), .flag_q(flag_q),
    .clr_stb(clr_stb), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .rdata(bus_rdata), .irq(irq)
  );
endmodule

// File: rtl/evtmr_chk.sv
module evtmr_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             flag,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             clr,
  input logic             ld_lo,
  input logic             ld_hi,
  input logic             step,
  input logic             rise,
  input logic             fall
);
  // R5: the request never stands without the flag behind it
  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);

  // R5: a rollover that is not cancelled leaves the flag set
  assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (step && (&cnt) && !clr) |=> flag);

  // R7: a clear strobe empties the count
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  // R7: a clear never produces a flag
  assert_clear_no_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && !flag) |=> !flag);

  // R4: halted and untouched by software, the count holds
  assert_halt_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr && !ld_lo && !ld_hi) |=> (cnt == $past(cnt)));

  // R8: running without an event, loads leave the count alone
  assert_run_load_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (run && !step && !clr) |=> (cnt == $past(cnt)));

  // R2: every accepted event adds exactly one
  assert_step_adds_one_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R3: a sampled transition is never both rising and falling
  assert_edge_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall));
endmodule

bind evtmr_top evtmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run_q), .flag(flag_q), .irq(irq), .cnt(cnt_q),
  .clr(clr_stb), .ld_lo(ld_lo), .ld_hi(ld_hi), .step(step),
  .rise(rise), .fall(fall)
);

// File: tb/evtmr_top_tb.sv
`timescale 1ns/1ps
module evtmr_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       ext_in = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  evtmr_top u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ext_in(ext_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] cw(bit run, bit ie, logic [1:0] m,
                                    bit keepf = 1'b1, bit keepc = 1'b1);
    return {2'b00, keepc, m, keepf, ie, run};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd1, lo);
    rd(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
    end
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_in = 1'b1;
      @(negedge clk);
      @(negedge clk); ext_in = 1'b0;
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic load(logic [15:0] v);
    wr(2'd0, cw(0, 0, 2'b00));
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic t_reset;
    logic [7:0] c; logic [15:0] v;
    check("R1 irq after reset", irq, 1'b0);
    rd(2'd0, c);
    check("R1 control after reset", c, 8'h20);
    rd16(v);
    check("R1 count after reset", v, 16'h0000);
  endtask

  task automatic t_timer;
    logic [15:0] v;
    wr(2'd0, cw(0, 0, 2'b00, 1, 0));
    wr(2'd0, cw(1, 0, 2'b00));
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      tick_en = (i % 3) != 0;
      ext_in  = i[0];
    end
    @(negedge clk); tick_en = 1'b0; ext_in = 1'b0;
    wr(2'd0, cw(0, 0, 2'b00));
    repeat (5) @(negedge clk);
    rd16(v);
    check("R2 timer counts ticks only", v, 16'd13);
  endtask

  task automatic t_edges;
    logic [15:0] v;
    for (int m = 1; m < 4; m++) begin
      wr(2'd0, cw(0, 0, 2'(m), 1, 0));
      wr(2'd0, cw(1, 0, 2'(m)));
      tick_en = 1'b1;
      pulses(5);
      tick_en = 1'b0;
      wr(2'd0, cw(0, 0, 2'(m)));
      rd16(v);
      // R10: two-cycle phases must all be seen
      check($sformatf("R3 R10 edge mode %0d", m), v, (m == 3) ? 16'd10 : 16'd5);
    end
  endtask

  task automatic t_halt;
    logic [15:0] v;
    load(16'h0042);
    wr(2'd0, cw(0, 0, 2'b11));
    tick_en = 1'b1;
    pulses(3);
    tick_en = 1'b0;
    rd16(v);
    check("R4 halted edge mode holds", v, 16'h0042);
    wr(2'd0, cw(0, 0, 2'b00));
    ticks(6);
    rd16(v);
    check("R4 halted timer mode holds", v, 16'h0042);
  endtask

  task automatic t_overflow;
    logic [7:0] c; logic [15:0] v;
    load(16'hFFFE);
    wr(2'd0, cw(1, 1, 2'b00));
    ticks(1);
    check("R5 no irq before wrap", irq, 1'b0);
    ticks(1);
    check("R5 irq after wrap", irq, 1'b1);
    rd(2'd0, c);
    check("R5 flag bit set", c, 8'h27);
    rd16(v);
    check("R5 count wrapped", v, 16'h0000);
    wr(2'd0, cw(1, 1, 2'b00, 1));
    check("R6 write one keeps flag", irq, 1'b1);
    wr(2'd0, cw(1, 1, 2'b00, 0));
    check("R6 write zero clears irq", irq, 1'b0);
    rd(2'd0, c);
    check("R6 flag bit cleared", c, 8'h23);
    load(16'hFFFF);
    wr(2'd0, cw(1, 0, 2'b00));
    ticks(1);
    check("R5 masked flag gives no irq", irq, 1'b0);
    rd(2'd0, c);
    check("R5 masked flag still set", c, 8'h25);
    wr(2'd0, cw(0, 0, 2'b00, 0));
  endtask

  task automatic t_clear_vs_wrap;
    logic [7:0] c; logic [15:0] v;
    load(16'hFFFF);
    wr(2'd0, cw(1, 1, 2'b00));
    @(negedge clk);
    tick_en = 1'b1;
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = cw(1, 1, 2'b00, 1, 0);
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    check("R7 no irq when clear meets wrap", irq, 1'b0);
    rd(2'd0, c);
    check("R7 flag clear and bit5 reads one", c, 8'h23);
    rd16(v);
    check("R7 count cleared", v, 16'h0000);
    ticks(3);
    wr(2'd0, cw(1, 1, 2'b00, 1, 0));
    wr(2'd0, cw(0, 0, 2'b00));
    rd16(v);
    check("R7 clear while running", v, 16'h0000);
  endtask

  task automatic t_load;
    logic [15:0] v;
    load(16'h1234);
    rd16(v);
    check("R8 load while halted", v, 16'h1234);
    wr(2'd0, cw(1, 0, 2'b00));
    wr(2'd1, 8'h55);
    wr(2'd2, 8'h66);
    rd16(v);
    check("R8 load while running ignored", v, 16'h1234);
    wr(2'd0, cw(0, 0, 2'b00));
  endtask

  task automatic t_snapshot;
    logic [7:0] d;
    load(16'h34FF);
    wr(2'd0, cw(1, 0, 2'b00));
    rd(2'd1, d);
    check("R9 low byte", d, 8'hFF);
    ticks(1);
    rd(2'd2, d);
    check("R9 high byte from snapshot", d, 8'h34);
    rd(2'd1, d);
    check("R9 low byte after step", d, 8'h00);
    rd(2'd2, d);
    check("R9 high byte after step", d, 8'h35);
    wr(2'd0, cw(0, 0, 2'b00));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_timer();
    t_edges();
    t_halt();
    t_overflow();
    t_clear_vs_wrap();
    t_load();
    t_snapshot();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule